// File: doc/BRIEF.md
# SPI Flash Cycle Sequencer

This block lets software run complete serial-flash operations by writing a few registers. Software loads a flash address and, for a program operation, the bytes to store in a 64-byte buffer. It then writes one control word that holds a cycle kind (read, program or 4 KiB sector erase), a byte count and a start bit. The engine builds the whole command stream on a single-select SPI bus in mode 0. For program and erase it sends the write-enable command in its own select window. It then polls the flash status register until the flash reports idle, and only after that does it raise the completion flag.

Results are reported through sticky flags that software clears by writing ones. Three conditions refuse a start and send nothing on the bus: a program whose bytes would run past a 256-byte flash page, a reserved cycle code, and a program or erase while the lock flag is set. A read fills the buffer little-endian: byte n of the transfer lands in buffer word n/4 at bit 8*(n%4).

Top module: `spi_flash_seq`

## Requirements
- R1: After reset the status register reads 0x0000_0008 (only the erase-size field, bits 4:3, at code 1 = 4 KiB). Control and address read 0, select is high and the serial clock is low.
- R2: A control write with bit 0 = 1 and kind bits 2:1 = 0 sends 0x03, then three address bytes most significant first, then count+1 dummy bytes, where count is control bits 13:8. All of it goes in one select window.
- R3: The buffer sits at register words 16..31. Transfer byte n is word 16+n/4, bits 8*(n%4)+7 down to 8*(n%4). Read data is stored this way, and program data is taken this way.
- R4: Kind 2 (program) sends 0x06 alone in one select window, then 0x02, three address bytes and count+1 buffer bytes in a second window.
- R5: Kind 3 (erase) sends 0x06 alone, then 0x20 with three address bytes and no data.
- R6: After a program or erase, the engine repeats a window of 0x05 plus one read byte until bit 0 of the returned byte is 0. Status bit 0 (done) is set only after that.
- R7: A program where address bits 7:0 plus count exceed 255 sends nothing and sets status bit 1 (cycle error) instead of done. A program ending exactly on the page end runs normally.
- R8: Status bits 0, 1 and 2 stay set until a status write with a 1 in that bit. Writing 0 leaves them unchanged.
- R9: Status bit 5 reads 1 from the start write until the cycle completes.
- R10: While a cycle is in progress, writes to the control and address registers are ignored, including a new start.
- R11: Writing 1 to status bit 15 sets a lock flag that only reset clears. While it is set, program and erase starts send nothing and set status bit 2 (access error). Reads still run.
- R12: A start with reserved kind 1 sends nothing and sets status bit 2.
- R13: The address register (word 2) reads back all 32 written bits. Only bits 23:0 are sent on the bus.
- R14: The serial clock is low whenever select is high. MOSI changes on falling edges and MISO is sampled on rising edges (mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register word address (0 control, 1 status, 2 address, 16..31 buffer) |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Flash select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest state to reach from the ports is the busy-poll loop: completion must wait through several status windows that report busy. A bench flash model stays busy for exactly two polls after each program or erase window. The bench therefore expects three poll windows, and it counts them at the moment it sees completion. A second hard case is a start arriving mid-cycle. The bench writes a conflicting control word and a new address right after a program begins, and the scoreboard of bus bytes catches any stray window.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_RSVD  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_ERASE = 2'd3
  } cyc_kind_e;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SERASE = 8'h20;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 1;
  localparam int REG_ADDR = 2;

  // True when a program of cnt_m1+1 bytes from page offset lo leaves the page.
  function automatic logic crosses_page(input logic [7:0] lo, input logic [7:0] cnt_m1);
    logic [8:0] last;
    last = {1'b0, lo} + {1'b0, cnt_m1};
    return last[8];
  endfunction

endpackage

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  logic [7:0] sh;
  logic [2:0] bitn;
  logic       active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; bitn <= '0; active <= 1'b0; sck <= 1'b0; done <= 1'b0; rx <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh <= tx; bitn <= '0; active <= 1'b1; sck <= 1'b0;
      end else if (active) begin
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck  <= 1'b0;
          sh   <= {sh[6:0], 1'b0};
          bitn <= bitn + 3'd1;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end
      end
    end
  end

  assign mosi = sh[7];

endmodule

// File: rtl/spi_seq_buffer.sv
module spi_seq_buffer #(
  parameter int WORDS = 16,
  localparam int WI_W = $clog2(WORDS),
  localparam int BI_W = $clog2(WORDS * 4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_en,
  input  logic [WI_W-1:0] hw_idx,
  input  logic [31:0]     hw_data,
  input  logic [WI_W-1:0] hr_idx,
  output logic [31:0]     hr_data,
  input  logic            ew_en,
  input  logic [BI_W-1:0] ew_idx,
  input  logic [7:0]      ew_byte,
  input  logic [BI_W-1:0] er_idx,
  output logic [7:0]      er_byte
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (hw_en) begin
      mem[hw_idx] <= hw_data;
    end else if (ew_en) begin
      mem[ew_idx[BI_W-1:2]][8*ew_idx[1:0] +: 8] <= ew_byte;
    end
  end

  assign hr_data = mem[hr_idx];
  assign er_byte = mem[er_idx[BI_W-1:2]][8*er_idx[1:0] +: 8];

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int BI_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  cyc_kind_e       kind,
  input  logic [BI_W-1:0] cnt_m1,
  input  logic [23:0]     faddr,
  input  logic            locked,
  input  logic            sh_done,
  input  logic [7:0]      sh_rx,
  input  logic [7:0]      buf_byte,
  output logic            sh_start,
  output logic [7:0]      sh_tx,
  output logic            cs_n,
  output logic            busy,
  output logic [BI_W-1:0] rd_idx,
  output logic            wr_en,
  output logic [BI_W-1:0] wr_idx,
  output logic            done_evt,
  output logic            err_evt,
  output logic            acc_evt
);
  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_GAP1, S_CMD, S_ADDR, S_DATA, S_GAP2, S_POLLC, S_POLLR, S_FIN
  } st_e;

  st_e             st;
  logic [BI_W-1:0] idx;
  logic            acc_bad, page_bad, launch, is_wr, is_rd;

  assign is_wr    = (kind == KIND_WRITE);
  assign is_rd    = (kind == KIND_READ);
  assign acc_bad  = (kind == KIND_RSVD) || (locked && !is_rd);
  assign page_bad = is_wr && crosses_page(faddr[7:0], 8'(cnt_m1));
  assign launch   = go && (st == S_IDLE) && !acc_bad && !page_bad;
  assign acc_evt  = go && (st == S_IDLE) && acc_bad;
  assign err_evt  = go && (st == S_IDLE) && !acc_bad && page_bad;
  assign done_evt = (st == S_FIN);
  assign busy     = (st != S_IDLE);
  assign rd_idx   = (st == S_DATA) ? idx + 1'b1 : '0;
  assign wr_en    = (st == S_DATA) && sh_done && is_rd;
  assign wr_idx   = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; cs_n <= 1'b1; sh_start <= 1'b0; sh_tx <= '0;
    end else begin
      sh_start <= 1'b0;
      case (st)
        S_IDLE: if (launch) begin
          cs_n <= 1'b0; sh_start <= 1'b1; idx <= '0;
          sh_tx <= is_rd ? OP_READ : OP_WREN;
          st    <= is_rd ? S_CMD : S_WREN;
        end
        S_WREN: if (sh_done) begin cs_n <= 1'b1; st <= S_GAP1; end
        S_GAP1: begin
          cs_n <= 1'b0; sh_start <= 1'b1;
          sh_tx <= is_wr ? OP_PROG : OP_SERASE;
          st <= S_CMD;
        end
        S_CMD: if (sh_done) begin
          sh_start <= 1'b1; sh_tx <= faddr[23:16]; idx <= '0; st <= S_ADDR;
        end
        S_ADDR: if (sh_done) begin
          if (idx == BI_W'(2)) begin
            if (kind == KIND_ERASE) begin
              cs_n <= 1'b1; st <= S_GAP2;
            end else begin
              sh_start <= 1'b1; sh_tx <= is_wr ? buf_byte : 8'h00; idx <= '0; st <= S_DATA;
            end
          end else begin
            sh_start <= 1'b1;
            sh_tx <= (idx == '0) ? faddr[15:8] : faddr[7:0];
            idx <= idx + 1'b1;
          end
        end
        S_DATA: if (sh_done) begin
          if (idx == cnt_m1) begin
            cs_n <= 1'b1;
            st   <= is_rd ? S_FIN : S_GAP2;
          end else begin
            sh_start <= 1'b1; sh_tx <= is_wr ? buf_byte : 8'h00; idx <= idx + 1'b1;
          end
        end
        S_GAP2: begin cs_n <= 1'b0; sh_start <= 1'b1; sh_tx <= OP_RDSR; st <= S_POLLC; end
        S_POLLC: if (sh_done) begin sh_start <= 1'b1; sh_tx <= 8'h00; st <= S_POLLR; end
        S_POLLR: if (sh_done) begin
          cs_n <= 1'b1;
          st   <= sh_rx[0] ? S_GAP2 : S_FIN;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6: a program/erase completes only when the last polled status byte was idle
  p_done_after_idle_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !is_rd) |-> !sh_rx[0]);

  // R7: a refused program leaves the engine idle
  p_refused_stays_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> !busy);

  // R11/R12: access-refused starts never open a select window
  p_refused_no_select_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> cs_n);

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_seq_pkg::*;
#(
  parameter int          BUF_WORDS  = 16,
  parameter logic [1:0]  ERASE_CODE = 2'd1,
  localparam int REG_AW = $clog2(BUF_WORDS) + 1,
  localparam int WI_W   = $clog2(BUF_WORDS),
  localparam int BI_W   = $clog2(BUF_WORDS * 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_wr,
  output logic [31:0]       reg_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  cyc_kind_e       ctl_kind;
  logic [BI_W-1:0] ctl_cnt;
  logic [31:0]     faddr_q;
  logic            go_q, st_done, st_err, st_acc, lock_q;
  logic            eng_busy, busy_any;
  logic            wr_ctrl, wr_stat, wr_addr, wr_buf, buf_sel;
  logic            sh_start, sh_done;
  logic [7:0]      sh_tx, sh_rx, buf_byte;
  logic [BI_W-1:0] rd_idx, wr_idx;
  logic            ewr_en, done_evt, err_evt, acc_evt;
  logic [31:0]     hr_data;

  assign buf_sel  = reg_addr[REG_AW-1];
  assign busy_any = eng_busy | go_q;
  assign wr_ctrl  = reg_wr && !buf_sel && (reg_addr == REG_AW'(REG_CTRL));
  assign wr_stat  = reg_wr && !buf_sel && (reg_addr == REG_AW'(REG_STAT));
  assign wr_addr  = reg_wr && !buf_sel && (reg_addr == REG_AW'(REG_ADDR));
  assign wr_buf   = reg_wr && buf_sel && !busy_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_kind <= KIND_READ; ctl_cnt <= '0; faddr_q <= '0; go_q <= 1'b0;
      st_done <= 1'b0; st_err <= 1'b0; st_acc <= 1'b0; lock_q <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (wr_ctrl && !busy_any) begin
        ctl_kind <= cyc_kind_e'(reg_wdata[2:1]);
        ctl_cnt  <= reg_wdata[8 +: BI_W];
        go_q     <= reg_wdata[0];
      end
      if (wr_addr && !busy_any) faddr_q <= reg_wdata;
      st_done <= done_evt | (st_done & ~(wr_stat & reg_wdata[0]));
      st_err  <= err_evt  | (st_err  & ~(wr_stat & reg_wdata[1]));
      st_acc  <= acc_evt  | (st_acc  & ~(wr_stat & reg_wdata[2]));
      lock_q  <= lock_q | (wr_stat & reg_wdata[15]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (buf_sel) begin
      reg_rdata = hr_data;
    end else if (reg_addr == REG_AW'(REG_CTRL)) begin
      reg_rdata[8 +: BI_W] = ctl_cnt;
      reg_rdata[2:1]       = ctl_kind;
    end else if (reg_addr == REG_AW'(REG_STAT)) begin
      reg_rdata[0]   = st_done;
      reg_rdata[1]   = st_err;
      reg_rdata[2]   = st_acc;
      reg_rdata[4:3] = ERASE_CODE;
      reg_rdata[5]   = busy_any;
      reg_rdata[15]  = lock_q;
    end else if (reg_addr == REG_AW'(REG_ADDR)) begin
      reg_rdata = faddr_q;
    end
  end

  spi_seq_buffer #(.WORDS(BUF_WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .hw_en(wr_buf), .hw_idx(reg_addr[WI_W-1:0]), .hw_data(reg_wdata),
    .hr_idx(reg_addr[WI_W-1:0]), .hr_data(hr_data),
    .ew_en(ewr_en), .ew_idx(wr_idx), .ew_byte(sh_rx),
    .er_idx(rd_idx), .er_byte(buf_byte)
  );

  spi_seq_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx)
  );

  spi_seq_ctrl #(.BI_W(BI_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go_q), .kind(ctl_kind), .cnt_m1(ctl_cnt),
    .faddr(faddr_q[23:0]), .locked(lock_q), .sh_done(sh_done), .sh_rx(sh_rx),
    .buf_byte(buf_byte), .sh_start(sh_start), .sh_tx(sh_tx), .cs_n(spi_cs_n),
    .busy(eng_busy), .rd_idx(rd_idx), .wr_en(ewr_en), .wr_idx(wr_idx),
    .done_evt(done_evt), .err_evt(err_evt), .acc_evt(acc_evt)
  );

  // R14: serial clock idles low outside a select window
  p_sck_low_deselected_r14: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R10: control fields hold while a cycle is pending or running
  p_ctrl_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_any && wr_ctrl) |=> ($stable(ctl_kind) && $stable(ctl_cnt)));

  // R8: done flag persists until cleared by a one
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_done && !(wr_stat && reg_wdata[0])) |=> st_done);

  // R11: lock never drops once set
  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

endmodule

// File: tb/spi_flash_seq_bench.sv
`timescale 1ns/1ps
module spi_flash_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

  always #4 clk = ~clk;

  spi_flash_seq u_spi_flash_seq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // scoreboard of expected bus bytes and window lengths
  logic [7:0] exp_byte[$];
  string      exp_tag[$];
  int         exp_len[$];
  int         pend_len = 0;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic exp_b(input string t, input logic [7:0] b);
    exp_byte.push_back(b); exp_tag.push_back(t); pend_len++;
  endtask
  task automatic exp_end();
    exp_len.push_back(pend_len); pend_len = 0;
  endtask
  task automatic exp_polls(input string t);
    for (int i = 0; i < 3; i++) begin exp_b(t, 8'h05); exp_b(t, 8'h00); exp_end(); end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic wait_end(output logic [31:0] s);
    s = '0;
    for (int n = 0; n < 20000; n++) begin
      rd(5'd1, s);
      if (s[2:0] != 3'b000) break;
    end
  endtask

  // flash model and monitor
  logic [7:0]  in_sh = '0, out_sh = '0, nxt_out = '0, f0 = '0;
  logic [23:0] fa = '0;
  int bitc = 0, bytec = 0, busy_left = 0, frames_seen = 0, poll_frames = 0;
  bit in_frame = 0;
  assign spi_miso = out_sh[7];

  always @(negedge spi_cs_n) begin
    bitc = 0; bytec = 0; out_sh = '0; in_frame = 1; f0 = '0;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    in_sh = {in_sh[6:0], spi_mosi};
    bitc++;
    if (bitc % 8 == 0) begin
      checks++;
      if (exp_byte.size() == 0) begin
        fails++;
        $display("FAIL unexpected bus byte: actual=%h expected=none", in_sh);
      end else begin
        logic [7:0] eb; string et;
        eb = exp_byte.pop_front(); et = exp_tag.pop_front();
        if (in_sh !== eb) begin
          fails++;
          $display("FAIL %s: bus byte %0d actual=%h expected=%h", et, bytec, in_sh, eb);
        end
      end
      if (bytec == 0) f0 = in_sh;
      if (bytec >= 1 && bytec <= 3) fa = {fa[15:0], in_sh};
      nxt_out = 8'h00;
      if (f0 == 8'h03 && bytec >= 3) nxt_out = pat(fa + 24'(bytec - 3));
      if (f0 == 8'h05 && bytec == 0) begin
        nxt_out = (busy_left > 0) ? 8'h01 : 8'h00;
        if (busy_left > 0) busy_left--;
      end
      bytec++;
    end
  end

  always @(negedge spi_sck) if (!spi_cs_n) begin
    if (bitc % 8 == 0) out_sh = nxt_out;
    else out_sh = {out_sh[6:0], 1'b0};
  end

  always @(posedge spi_cs_n) if (in_frame) begin
    in_frame = 0;
    frames_seen++;
    if (f0 == 8'h05) poll_frames++;
    if (f0 == 8'h02 || f0 == 8'h20) busy_left = 2;
    checks++;
    if (exp_len.size() == 0) begin
      fails++;
      $display("FAIL unexpected select window: actual=%0d bytes expected=none", bytec);
    end else begin
      int el;
      el = exp_len.pop_front();
      if (el != bytec) begin
        fails++;
        $display("FAIL window length: actual=%0d expected=%0d", bytec, el);
      end
    end
  end

  task automatic sb_empty(input string t);
    check(t, 32'(exp_byte.size() + exp_len.size()), 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, w;
    int fs;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(5'd1, s); check("R1 status", s, 32'h8);
    rd(5'd0, s); check("R1 control", s, 32'h0);
    rd(5'd2, s); check("R1 address", s, 32'h0);
    check("R1 select", {30'd0, spi_cs_n, spi_sck}, 32'h2);

    // R2/R3/R9/R8: read 8 bytes at 0x012345
    wr(5'd2, 32'h0001_2345);
    exp_b("R2", 8'h03); exp_b("R2", 8'h01); exp_b("R2", 8'h23); exp_b("R2", 8'h45);
    for (int i = 0; i < 8; i++) exp_b("R2", 8'h00);
    exp_end();
    wr(5'd0, (32'd7 << 8) | 32'd1);
    rd(5'd1, s); check("R9 in progress", {31'd0, s[5]}, 32'd1);
    wait_end(s);
    check("R2 status done", s, 32'h9);
    for (int k = 0; k < 2; k++) begin
      rd(5'(16 + k), w);
      check("R3 read packing", w, {pat(24'h012345 + 24'(4*k+3)), pat(24'h012345 + 24'(4*k+2)),
                                   pat(24'h012345 + 24'(4*k+1)), pat(24'h012345 + 24'(4*k))});
    end
    sb_empty("R2 window set");
    wr(5'd1, 32'h6); rd(5'd1, s); check("R8 other bits leave done", s, 32'h9);
    wr(5'd1, 32'h0); rd(5'd1, s); check("R8 zero write no effect", s, 32'h9);
    wr(5'd1, 32'h1); rd(5'd1, s); check("R8 clear done", s, 32'h8);

    // R13/R2: 64-byte read with upper address bits set
    wr(5'd2, 32'hFF00_0100);
    rd(5'd2, s); check("R13 address readback", s, 32'hFF00_0100);
    exp_b("R13", 8'h03); exp_b("R13", 8'h00); exp_b("R13", 8'h01); exp_b("R13", 8'h00);
    for (int i = 0; i < 64; i++) exp_b("R2", 8'h00);
    exp_end();
    wr(5'd0, (32'd63 << 8) | 32'd1);
    wait_end(s);
    check("R2 64B done", s, 32'h9);
    for (int k = 0; k < 16; k++) begin
      rd(5'(16 + k), w);
      check("R3 full buffer", w, {pat(24'h100 + 24'(4*k+3)), pat(24'h100 + 24'(4*k+2)),
                                  pat(24'h100 + 24'(4*k+1)), pat(24'h100 + 24'(4*k))});
    end
    sb_empty("R2 64B window");
    wr(5'd1, 32'h1);

    // R4/R6/R10: program 6 bytes at 0x000210
    wr(5'd16, 32'hDDCC_BBAA); wr(5'd17, 32'h4433_2211);
    wr(5'd2, 32'h0000_0210);
    exp_b("R4", 8'h06); exp_end();
    exp_b("R4", 8'h02); exp_b("R4", 8'h00); exp_b("R4", 8'h02); exp_b("R4", 8'h10);
    exp_b("R3", 8'hAA); exp_b("R3", 8'hBB); exp_b("R3", 8'hCC); exp_b("R3", 8'hDD);
    exp_b("R3", 8'h11); exp_b("R3", 8'h22); exp_end();
    exp_polls("R6");
    poll_frames = 0;
    wr(5'd0, (32'd5 << 8) | (32'd2 << 1) | 32'd1);
    wr(5'd0, (32'd3 << 8) | 32'd1);
    wr(5'd2, 32'h0077_7777);
    wait_end(s);
    check("R6 done after polls", s, 32'h9);
    check("R6 poll windows", 32'(poll_frames), 32'd3);
    rd(5'd0, s); check("R10 control held", s, (32'd5 << 8) | 32'd4);
    rd(5'd2, s); check("R10 address held", s, 32'h210);
    sb_empty("R4 windows");
    wr(5'd1, 32'h1);

    // R5: erase at 0x003000
    wr(5'd2, 32'h0000_3000);
    exp_b("R5", 8'h06); exp_end();
    exp_b("R5", 8'h20); exp_b("R5", 8'h00); exp_b("R5", 8'h30); exp_b("R5", 8'h00); exp_end();
    exp_polls("R6");
    wr(5'd0, (32'd3 << 1) | 32'd1);
    wait_end(s);
    check("R5 erase done", s, 32'h9);
    sb_empty("R5 windows");
    wr(5'd1, 32'h1);

    // R7: program ending exactly at page end
    for (int k = 0; k < 4; k++) wr(5'(16 + k), 32'h0302_0100 + 32'(k) * 32'h0404_0404);
    wr(5'd2, 32'h0000_00F0);
    exp_b("R7", 8'h06); exp_end();
    exp_b("R7", 8'h02); exp_b("R7", 8'h00); exp_b("R7", 8'h00); exp_b("R7", 8'hF0);
    for (int i = 0; i < 16; i++) exp_b("R7", 8'(i));
    exp_end();
    exp_polls("R6");
    wr(5'd0, (32'd15 << 8) | (32'd2 << 1) | 32'd1);
    wait_end(s);
    check("R7 boundary allowed", s, 32'h9);
    sb_empty("R7 boundary windows");
    wr(5'd1, 32'h1);

    // R7: crossing program refused
    fs = frames_seen;
    wr(5'd0, (32'd16 << 8) | (32'd2 << 1) | 32'd1);
    wait_end(s);
    check("R7 crossing error", s, 32'hA);
    repeat (40) @(negedge clk);
    check("R7 no bus activity", 32'(frames_seen), 32'(fs));
    wr(5'd1, 32'h2); rd(5'd1, s); check("R8 clear error", s, 32'h8);

    // R12: reserved kind
    wr(5'd0, (32'd1 << 1) | 32'd1);
    wait_end(s);
    check("R12 access error", s, 32'hC);
    repeat (40) @(negedge clk);
    check("R12 no bus activity", 32'(frames_seen), 32'(fs));
    wr(5'd1, 32'h4);

    // R11: lock
    wr(5'd1, 32'h8000); rd(5'd1, s); check("R11 lock set", s, 32'h8008);
    wr(5'd1, 32'h0);    rd(5'd1, s); check("R11 lock holds", s, 32'h8008);
    wr(5'd2, 32'h0000_0005);
    wr(5'd0, (32'd3 << 1) | 32'd1);
    wait_end(s);
    check("R11 erase refused", s, 32'h800C);
    repeat (40) @(negedge clk);
    check("R11 no bus activity", 32'(frames_seen), 32'(fs));
    wr(5'd1, 32'h4);
    exp_b("R11", 8'h03); exp_b("R11", 8'h00); exp_b("R11", 8'h00); exp_b("R11", 8'h05);
    exp_b("R11", 8'h00); exp_end();
    wr(5'd0, 32'd1);
    wait_end(s);
    check("R11 read while locked", s, 32'h8009);
    rd(5'd16, w); check("R11 read data", {24'd0, w[7:0]}, {24'd0, pat(24'h5)});
    check("R14 idle bus", {30'd0, spi_cs_n, spi_sck}, 32'h2);
    sb_empty("R11 windows");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule